// File: doc/BRIEF.md
# Pending-Fetch Register Interlock Scoreboard

This block tracks which registers of a 256-entry register file are still waiting for words from outstanding multi-word memory fetches, and decides for each presented instruction whether it must stall, must be aborted, or may proceed. A fetch of one, two or four words marks that many consecutive registers, starting at its target, as pending. Each memory fill completion clears one register.

The interlock is selective on purpose. Ordinary ALU-path reads stall on a pending register, and so does the base register of a memory reference. Writes of a constant or of T do not stall, and neither do branch tests that only sample a register's sign or low bit. A later fill then silently replaces such a write, so the block raises a one-cycle clobber warning that carries the register address. I/O-style references (input, output, pipe read) use register 0 of the current 16-register group as their base unless an explicit base is supplied. A stack-pointer decrement while the stack-top register is pending aborts the instruction.

The instruction presented on a cycle takes effect at the clock edge only when it is valid, not stalled and not aborted. Stall and abort are combinational from the registered pending state.

Top module: `sb_interlock_scoreboard`

## Requirements
- R1: `fetch_size` encodes the word count as 0 for one word, 1 for two and 2 or 3 for four. An accepted fetch marks registers target through target+count-1 as pending, with addresses wrapping modulo 256. Each register stops being pending in the cycle after a fill naming it. Stall and abort depend only on the registered pending state.
- R2: When `src_kind` is 0 (register source) and `br_only` is low, a valid instruction whose `rd_reg` is pending stalls.
- R3: When `src_kind` is 1 (constant) or 2 (T), `rd_reg` is ignored and the write does not stall. The destination stays pending, so a later register read of it still stalls.
- R4: With `br_only` high, a pending `rd_reg` does not stall.
- R5: When `mref_vld` is high, a pending `mref_base` stalls the instruction.
- R6: When `mref_io` is high and `base_given` is low, the base register checked is `{cur_group, 4'h0}` and `mref_base` is ignored. When `base_given` is high, `mref_base` is used.
- R7: A valid instruction with `stk_dec` high whose `stk_ptr` register is pending is aborted. `abort` goes high and `stall` stays low.
- R8: An executed write (`wr_vld`) to a pending register raises `clobber_vld` for exactly the following cycle, with `clobber_reg` equal to `wr_reg`.
- R9: A fetch whose register range overlaps any pending register stalls until those registers are filled.
- R10: After reset no register is pending, and `stall`, `abort` and `clobber_vld` are low.
- R11: A stalled or aborted instruction marks no registers and raises no clobber warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_vld | input | 1 | An instruction is presented this cycle |
| fetch_vld | input | 1 | Instruction issues a register fetch |
| fetch_size | input | 2 | Fetch word count code |
| fetch_reg | input | 8 | First target register of the fetch |
| fill_vld | input | 1 | Memory delivers one fetched word |
| fill_reg | input | 8 | Register receiving that word |
| rd_reg | input | 8 | Register read through the ALU path |
| src_kind | input | 2 | 0 register, 1 constant, 2 T |
| br_only | input | 1 | Register is sampled only by a sign/odd branch test |
| wr_vld | input | 1 | Instruction writes a register |
| wr_reg | input | 8 | Destination register |
| mref_vld | input | 1 | Instruction is a memory reference |
| mref_base | input | 8 | Base register named by the reference |
| mref_io | input | 1 | Reference is input, output or pipe read |
| base_given | input | 1 | I/O reference carries an explicit base |
| cur_group | input | 4 | Current 16-register group |
| stk_dec | input | 1 | Instruction decrements the stack pointer |
| stk_ptr | input | 8 | Register at the stack top |
| stall | output | 1 | Instruction must be held |
| abort | output | 1 | Instruction is aborted |
| clobber_vld | output | 1 | A non-interlocked write hit a pending register |
| clobber_reg | output | 8 | Address of that register |

## Verification
The bench builds the block with its defaults: 256 registers in groups of 16. With these values a two-word fetch at register 0xFF wraps onto register 0x00, and an I/O reference in group 1 defaults to register 0x10. That default collides with a four-word fetch at 0x10. The vector walk runs a single pending-state history through each interlock path, including a stalled write that must not warn and an aborted fetch that must not mark. A directed reset in the middle of the run checks that the pending state is wiped.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        SRC_REG   = 2'd0,
        SRC_CONST = 2'd1,
        SRC_T     = 2'd2,
        SRC_RSVD  = 2'd3
    } src_kind_e;

    // word count of a fetch: code 0 -> 1, 1 -> 2, 2/3 -> 4
    function automatic logic [2:0] fetch_words(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/sb_fetch_mask.sv
module sb_fetch_mask #(
    parameter int NREGS  = 256,
    parameter int ADDR_W = $clog2(NREGS)
) (
    input  logic              en,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] first,
    output logic [NREGS-1:0]  mask
);
    import sb_pkg::*;

    logic [ADDR_W-1:0] cnt;
    assign cnt = ADDR_W'(fetch_words(size));

    for (genvar i = 0; i < NREGS; i++) begin : g_slot
        logic [ADDR_W-1:0] off;
        assign off     = ADDR_W'(i) - first;
        assign mask[i] = en && (off < cnt);
    end

endmodule

// File: rtl/sb_pending.sv
module sb_pending #(
    parameter int NREGS  = 256,
    parameter int ADDR_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [NREGS-1:0]  set_mask,
    input  logic              fill_vld,
    input  logic [ADDR_W-1:0] fill_reg,
    output logic [NREGS-1:0]  pend
);
    typedef struct packed {
        logic [NREGS-1:0] pend;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        logic [NREGS-1:0] clr;
        st_d = st_q;
        clr  = fill_vld ? (NREGS'(1) << fill_reg) : '0;
        st_d.pend = (st_q.pend & ~clr) | (set_en ? set_mask : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    AST_FILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_vld && st_q.pend[fill_reg] && !(set_en && set_mask[fill_reg]))
            |=> !st_q.pend[$past(fill_reg)]); // R1

endmodule

// File: rtl/sb_hazard.sv
module sb_hazard #(
    parameter int NREGS  = 256,
    parameter int ADDR_W = $clog2(NREGS),
    parameter int GRP_W  = 4
) (
    input  logic                    instr_vld,
    input  logic [NREGS-1:0]        pend,
    input  logic [NREGS-1:0]        fetch_mask,
    input  logic [ADDR_W-1:0]       rd_reg,
    input  logic [1:0]              src_kind,
    input  logic                    br_only,
    input  logic                    mref_vld,
    input  logic [ADDR_W-1:0]       mref_base,
    input  logic                    mref_io,
    input  logic                    base_given,
    input  logic [ADDR_W-GRP_W-1:0] cur_group,
    input  logic                    stk_dec,
    input  logic [ADDR_W-1:0]       stk_ptr,
    output logic                    stall,
    output logic                    abort
);
    import sb_pkg::*;

    logic [ADDR_W-1:0] base_eff;
    logic rd_hit, base_hit, fetch_hit, stk_hit;

    always_comb begin
        base_eff  = (mref_io && !base_given) ? {cur_group, {GRP_W{1'b0}}} : mref_base;
        rd_hit    = (src_kind_e'(src_kind) == SRC_REG) && !br_only && pend[rd_reg];
        base_hit  = mref_vld && pend[base_eff];
        fetch_hit = |(fetch_mask & pend);
        stk_hit   = stk_dec && pend[stk_ptr];
        abort     = instr_vld && stk_hit;
        stall     = instr_vld && !stk_hit && (rd_hit || base_hit || fetch_hit);
    end

endmodule

// File: rtl/sb_interlock_scoreboard.sv
module sb_interlock_scoreboard #(
    parameter int NREGS  = 256,
    parameter int GROUP  = 16,
    localparam int ADDR_W = $clog2(NREGS),
    localparam int GRP_W  = $clog2(GROUP)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    instr_vld,
    input  logic                    fetch_vld,
    input  logic [1:0]              fetch_size,
    input  logic [ADDR_W-1:0]       fetch_reg,
    input  logic                    fill_vld,
    input  logic [ADDR_W-1:0]       fill_reg,
    input  logic [ADDR_W-1:0]       rd_reg,
    input  logic [1:0]              src_kind,
    input  logic                    br_only,
    input  logic                    wr_vld,
    input  logic [ADDR_W-1:0]       wr_reg,
    input  logic                    mref_vld,
    input  logic [ADDR_W-1:0]       mref_base,
    input  logic                    mref_io,
    input  logic                    base_given,
    input  logic [ADDR_W-GRP_W-1:0] cur_group,
    input  logic                    stk_dec,
    input  logic [ADDR_W-1:0]       stk_ptr,
    output logic                    stall,
    output logic                    abort,
    output logic                    clobber_vld,
    output logic [ADDR_W-1:0]       clobber_reg
);
    typedef struct packed {
        logic              clob_vld;
        logic [ADDR_W-1:0] clob_reg;
    } warn_t;

    logic [NREGS-1:0] fmask, pend;
    logic             go;
    warn_t            w_d, w_q;

    sb_fetch_mask #(.NREGS(NREGS), .ADDR_W(ADDR_W)) u_mask (
        .en(fetch_vld), .size(fetch_size), .first(fetch_reg), .mask(fmask)
    );

    sb_hazard #(.NREGS(NREGS), .ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_haz (
        .instr_vld(instr_vld), .pend(pend), .fetch_mask(fmask),
        .rd_reg(rd_reg), .src_kind(src_kind), .br_only(br_only),
        .mref_vld(mref_vld), .mref_base(mref_base), .mref_io(mref_io),
        .base_given(base_given), .cur_group(cur_group),
        .stk_dec(stk_dec), .stk_ptr(stk_ptr), .stall(stall), .abort(abort)
    );

    assign go = instr_vld && !stall && !abort;

    sb_pending #(.NREGS(NREGS), .ADDR_W(ADDR_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_en(go), .set_mask(fmask),
        .fill_vld(fill_vld), .fill_reg(fill_reg), .pend(pend)
    );

    always_comb begin
        w_d          = w_q;
        w_d.clob_vld = go && wr_vld && pend[wr_reg];
        w_d.clob_reg = wr_reg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign clobber_vld = w_q.clob_vld;
    assign clobber_reg = w_q.clob_reg;

    AST_FETCH_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (go && fetch_vld && !(fill_vld && fill_reg == fetch_reg))
            |=> pend[$past(fetch_reg)]); // R1
    AST_READ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && !abort && src_kind == 2'd0 && !br_only && pend[rd_reg]) |-> stall); // R2
    AST_BASE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && !abort && mref_vld && !mref_io && pend[mref_base]) |-> stall); // R5
    AST_ABORT_NEEDS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (stk_dec && !stall)); // R7
    AST_CLOBBER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clobber_vld) |-> $past(pend[wr_reg] && !stall && !abort)); // R8
    AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (stall || abort) |=> !clobber_vld); // R11

endmodule

// File: tb/sb_interlock_scoreboard_test.sv
module sb_interlock_scoreboard_test;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic       instr_vld, fetch_vld, fill_vld, br_only, wr_vld;
    logic       mref_vld, mref_io, base_given, stk_dec;
    logic [1:0] fetch_size, src_kind;
    logic [7:0] fetch_reg, fill_reg, rd_reg, wr_reg, mref_base, stk_ptr;
    logic [3:0] cur_group;
    logic       stall, abort, clobber_vld;
    logic [7:0] clobber_reg;

    sb_interlock_scoreboard uut (
        .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .fetch_vld(fetch_vld),
        .fetch_size(fetch_size), .fetch_reg(fetch_reg), .fill_vld(fill_vld),
        .fill_reg(fill_reg), .rd_reg(rd_reg), .src_kind(src_kind), .br_only(br_only),
        .wr_vld(wr_vld), .wr_reg(wr_reg), .mref_vld(mref_vld), .mref_base(mref_base),
        .mref_io(mref_io), .base_given(base_given), .cur_group(cur_group),
        .stk_dec(stk_dec), .stk_ptr(stk_ptr), .stall(stall), .abort(abort),
        .clobber_vld(clobber_vld), .clobber_reg(clobber_reg)
    );

    typedef struct packed {
        logic       iv; logic fv; logic [1:0] fs; logic [7:0] freg;
        logic       flv; logic [7:0] flr;
        logic [7:0] rd; logic [1:0] src; logic br;
        logic       wv; logic [7:0] wr;
        logic       mv; logic [7:0] mb; logic mio; logic bg; logic [3:0] grp;
        logic       sd; logic [7:0] sp;
        logic       es; logic ea; logic ecv; logic [7:0] ecr;
    } vec_t;

    localparam int NV = 32;
    // iv fv fs freg  flv flr  rd src br  wv wr  mv mb mio bg grp  sd sp  es ea ecv ecr
    localparam vec_t VEC [NV] = '{
        '{1,1,2,8'h10, 0,8'h00, 8'h80,0,0, 0,8'h00, 1,8'h01,0,0,4'h0, 0,8'h00, 0,0,0,8'h00}, // R1 fetch4 @10
        '{1,0,0,8'h00, 0,8'h00, 8'h12,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 1,0,0,8'h00}, // R2
        '{1,0,0,8'h00, 0,8'h00, 8'h12,0,1, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,0,8'h00}, // R4
        '{1,0,0,8'h00, 0,8'h00, 8'h12,1,0, 1,8'h11, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,1,8'h11}, // R3 R8 const
        '{1,0,0,8'h00, 0,8'h00, 8'h13,2,0, 1,8'h13, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,1,8'h13}, // R3 R8 T
        '{1,0,0,8'h00, 0,8'h00, 8'h11,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 1,0,0,8'h00}, // R3 still pending
        '{1,0,0,8'h00, 0,8'h00, 8'h80,0,0, 0,8'h00, 1,8'h10,0,0,4'h0, 0,8'h00, 1,0,0,8'h00}, // R5
        '{1,0,0,8'h00, 0,8'h00, 8'h80,0,0, 0,8'h00, 1,8'h20,1,0,4'h1, 0,8'h00, 1,0,0,8'h00}, // R6 default base 10
        '{1,0,0,8'h00, 0,8'h00, 8'h80,0,0, 0,8'h00, 1,8'h20,1,1,4'h1, 0,8'h00, 0,0,0,8'h00}, // R6 given base
        '{1,1,1,8'h0F, 0,8'h00, 8'h80,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 1,0,0,8'h00}, // R9 overlap
        '{1,0,0,8'h00, 0,8'h00, 8'h12,0,0, 1,8'h11, 0,8'h00,0,0,4'h0, 0,8'h00, 1,0,0,8'h00}, // R11 stalled write
        '{0,0,0,8'h00, 1,8'h10, 8'h80,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,0,8'h00}, // fill 10
        '{1,0,0,8'h00, 0,8'h00, 8'h10,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,0,8'h00}, // R1 cleared
        '{1,0,0,8'h00, 0,8'h00, 8'h80,0,0, 0,8'h00, 1,8'h20,1,0,4'h1, 0,8'h00, 0,0,0,8'h00}, // R6 default clear
        '{1,1,1,8'h0F, 0,8'h00, 8'h80,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,0,8'h00}, // R9 accepted now
        '{1,0,0,8'h00, 0,8'h00, 8'h0F,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 1,0,0,8'h00}, // R1 0F pending
        '{1,1,1,8'hFF, 0,8'h00, 8'h80,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,0,8'h00}, // R1 wrap fetch
        '{1,0,0,8'h00, 0,8'h00, 8'h00,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 1,0,0,8'h00}, // R1 wrap reg 00
        '{1,1,0,8'h40, 0,8'h00, 8'h12,0,0, 1,8'h11, 0,8'h00,0,0,4'h0, 1,8'hFF, 0,1,0,8'h00}, // R7 R11 abort
        '{1,0,0,8'h00, 0,8'h00, 8'h40,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,0,8'h00}, // R11 no mark
        '{1,1,0,8'h50, 0,8'h00, 8'h80,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,0,8'h00}, // R1 fetch1
        '{1,0,0,8'h00, 0,8'h00, 8'h51,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,0,8'h00}, // R1 51 free
        '{1,0,0,8'h00, 0,8'h00, 8'h50,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 1,0,0,8'h00}, // R1 50 pending
        '{1,1,3,8'h60, 0,8'h00, 8'h80,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,0,8'h00}, // R1 code3 = 4
        '{1,0,0,8'h00, 0,8'h00, 8'h63,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 1,0,0,8'h00}, // R1 63 pending
        '{1,0,0,8'h00, 0,8'h00, 8'h64,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,0,8'h00}, // R1 64 free
        '{0,0,0,8'h00, 1,8'hFF, 8'h80,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,0,8'h00}, // fill FF
        '{1,0,0,8'h00, 0,8'h00, 8'h80,0,0, 1,8'h70, 0,8'h00,0,0,4'h0, 1,8'hFF, 0,0,0,8'h00}, // R7 no abort
        '{1,0,0,8'h00, 0,8'h00, 8'h80,0,0, 1,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,1,8'h00}, // R8 reg 00
        '{0,0,0,8'h00, 1,8'h13, 8'h80,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,0,8'h00}, // fill 13
        '{1,0,0,8'h00, 0,8'h00, 8'h13,1,0, 1,8'h13, 0,8'h00,0,0,4'h0, 0,8'h00, 0,0,0,8'h00}, // R8 no warn
        '{1,0,0,8'h00, 0,8'h00, 8'h12,0,0, 0,8'h00, 0,8'h00,0,0,4'h0, 0,8'h00, 1,0,0,8'h00}  // R2 12 pending
    };

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input logic cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        instr_vld = 0; fetch_vld = 0; fetch_size = 0; fetch_reg = 0;
        fill_vld = 0; fill_reg = 0; rd_reg = 8'h80; src_kind = 0; br_only = 0;
        wr_vld = 0; wr_reg = 0; mref_vld = 0; mref_base = 0; mref_io = 0;
        base_given = 0; cur_group = 0; stk_dec = 0; stk_ptr = 0;
    endtask

    task automatic apply(input vec_t v);
        instr_vld = v.iv; fetch_vld = v.fv; fetch_size = v.fs; fetch_reg = v.freg;
        fill_vld = v.flv; fill_reg = v.flr; rd_reg = v.rd; src_kind = v.src;
        br_only = v.br; wr_vld = v.wv; wr_reg = v.wr; mref_vld = v.mv;
        mref_base = v.mb; mref_io = v.mio; base_given = v.bg; cur_group = v.grp;
        stk_dec = v.sd; stk_ptr = v.sp;
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R10 reset state
        #1;
        check(!stall && !abort && !clobber_vld, "R10 reset outputs", {stall, abort, clobber_vld}, 0);
        for (int r = 0; r < 256; r += 17) begin
            @(negedge clk);
            instr_vld = 1; rd_reg = 8'(r); mref_vld = 1; mref_base = 8'(r);
            #1;
            check(!stall, "R10 nothing pending after reset", stall, 0);
        end
        @(negedge clk); idle();

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            #1;
            check(stall == VEC[i].es, $sformatf("vector %0d stall (R1-related tag in table)", i), stall, VEC[i].es);
            check(abort == VEC[i].ea, $sformatf("vector %0d abort R7", i), abort, VEC[i].ea);
            @(posedge clk);
            #1;
            check(clobber_vld == VEC[i].ecv, $sformatf("vector %0d clobber R8", i), clobber_vld, VEC[i].ecv);
            if (VEC[i].ecv)
                check(clobber_reg == VEC[i].ecr, $sformatf("vector %0d clobber addr R8", i), clobber_reg, VEC[i].ecr);
        end

        // R8 warning lasts one cycle only
        @(negedge clk); idle();
        instr_vld = 1; wr_vld = 1; wr_reg = 8'h12; src_kind = 1;
        @(posedge clk); #1;
        check(clobber_vld && clobber_reg == 8'h12, "R8 warn raised", clobber_reg, 8'h12);
        @(negedge clk); idle();
        @(posedge clk); #1;
        check(!clobber_vld, "R8 warn one cycle", clobber_vld, 0);

        // R10 reset mid-run clears pending registers
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        instr_vld = 1; rd_reg = 8'h12;
        #1;
        check(!stall, "R10 pending cleared by reset", stall, 0);
        rd_reg = 8'h50;
        #1;
        check(!stall, "R10 pending cleared by reset (50)", stall, 0);
        @(negedge clk); idle();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule